// File: doc/BRIEF.md
# Dual-Bank Register File with Exchange

This block holds the working registers of a small nibble-coded processor. There are two identical banks of 8-bit storage. Each bank has an accumulator, six general registers and a flag register that keeps carry and zero. One bank is active at any time. The datapath reads and writes only the active bank. The passive bank keeps its contents until it is selected again or an exchange reaches into it.

A decode stage presents a two-nibble operation code together with a strobe. The block runs the bank-level operations itself:
- toggle the active bank;
- swap the two accumulators across banks;
- swap the two flag registers across banks;
- swap the active accumulator with any other register of the active bank.

The ALU uses a combinational read port with a 3-bit selector, and sees the active accumulator and flags on dedicated outputs. Results come back through a single-cycle write-back port and a separate flag update port. Every change lands on the clock edge that samples it.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset (rst_ni low), bank 0 is active (bank_o = 0), and the accumulator, all six general registers and the flags of both banks read 0.
- R2: A strobed op code 0x99 makes the other bank active. It changes no register contents in either bank, including the flags.
- R3: A strobed op code 0x96 swaps the accumulators of the two banks. Nothing else changes.
- R4: A strobed op code 0x9A swaps the flag registers of the two banks. Nothing else changes.
- R5: A strobed op code 0x50 + r with r in 1..6 swaps the active accumulator with general register r of the active bank. The flags are unchanged.
- R6: A strobed op code 0x57 (target code 7, the flag register) loads the flags, zero-extended, into the active accumulator. It loads accumulator bits [1:0] into the flags.
- R7: A strobed op code 0x50 (target code 0, the accumulator) changes nothing.
- R8: The read port is combinational on the active bank. Selector 0 gives the accumulator, 1..6 give the general registers and 7 gives the flags. Flags appear as carry in bit 0, zero in bit 1, and zeros in bits 7:2, both on the read port and on flags_o.
- R9: With no strobe, wb_en_i writes wb_data_i into the active-bank register named by wb_sel_i, visible after the clock edge. For code 7 only bits [1:0] are kept.
- R10: With no strobe, flag_we_i loads flag_i into the active flags. It takes precedence over a write-back to code 7 in the same cycle.
- R11: In any cycle with op_valid_i high, write-back and flag update are ignored. A strobed code that is none of the above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Strobe for op_i |
| op_i | input | 8 | Two-nibble operation code; bits 2:0 carry the exchange target |
| rd_sel_i | input | 3 | Read port register selector |
| rd_data_o | output | 8 | Selected register of the active bank |
| wb_en_i | input | 1 | Write-back enable |
| wb_sel_i | input | 3 | Write-back register selector |
| wb_data_i | input | 8 | Write-back data |
| flag_we_i | input | 1 | Flag update enable |
| flag_i | input | 2 | New flags, carry in bit 0 and zero in bit 1 |
| acc_o | output | 8 | Active accumulator |
| flags_o | output | 8 | Active flags, zero-extended |
| bank_o | output | 1 | Index of the active bank |

## Verification
A register of the active bank that holds the wrong value shows on rd_data_o as soon as it is selected, in the cycle after the faulty edge. A wrong value on the accumulator or the flags shows on acc_o and flags_o at once. A fault in the passive bank cannot be seen until a bank toggle or a cross-bank exchange brings it forward. For that reason the bench sweeps all eight selector codes after every step. It also toggles the bank to compare the passive contents against a model built from the requirements. A long mixed sequence of operations, write-backs and flag updates catches ordering and precedence errors within a few cycles of the point where they occur.

// File: rtl/drf_pkg.sv
package drf_pkg;
  localparam int unsigned FLAG_W = 2;
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_Z  = 1;

  localparam logic [7:0] OPC_BANK = 8'h99;
  localparam logic [7:0] OPC_XACC = 8'h96;
  localparam logic [7:0] OPC_XFLG = 8'h9A;
  localparam logic [4:0] OPC_XREG = 5'b01010;

  typedef enum logic [2:0] {
    OPK_NONE,
    OPK_BANK,
    OPK_XACC,
    OPK_XFLG,
    OPK_XREG
  } op_kind_e;
endpackage

// File: rtl/drf_op_decode.sv
module drf_op_decode
  import drf_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] op_i,
  output op_kind_e   kind_o,
  output logic [2:0] tgt_o
);
  always_comb begin
    kind_o = OPK_NONE;
    if (valid_i) begin
      if (op_i == OPC_BANK)           kind_o = OPK_BANK;
      else if (op_i == OPC_XACC)      kind_o = OPK_XACC;
      else if (op_i == OPC_XFLG)      kind_o = OPK_XFLG;
      else if (op_i[7:3] == OPC_XREG) kind_o = OPK_XREG;
    end
  end
  assign tgt_o = op_i[2:0];
endmodule

// File: rtl/drf_bank.sv
module drf_bank #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_GPR = 6,
  parameter int unsigned FLAG_W  = 2,
  localparam int unsigned GPR_IW = $clog2(NUM_GPR)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             acc_we_i,
  input  logic [DATA_W-1:0]                acc_d_i,
  input  logic                             flg_we_i,
  input  logic [FLAG_W-1:0]                flg_d_i,
  input  logic                             gpr_we_i,
  input  logic [GPR_IW-1:0]                gpr_idx_i,
  input  logic [DATA_W-1:0]                gpr_d_i,
  output logic [DATA_W-1:0]                acc_o,
  output logic [FLAG_W-1:0]                flg_o,
  output logic [NUM_GPR-1:0][DATA_W-1:0]   gpr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_o <= '0;
    else if (acc_we_i) acc_o <= acc_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flg_o <= '0;
    else if (flg_we_i) flg_o <= flg_d_i;
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gpr_o[g] <= '0;
      else if (gpr_we_i && gpr_idx_i == GPR_IW'(g)) gpr_o[g] <= gpr_d_i;
    end
  end
endmodule

// File: rtl/drf_read_mux.sv
module drf_read_mux #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_GPR = 6,
  parameter int unsigned FLAG_W  = 2,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [DATA_W-1:0]              acc_i,
  input  logic [FLAG_W-1:0]              flg_i,
  input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_i,
  output logic [DATA_W-1:0]              data_o
);
  localparam logic [SEL_W-1:0] FLG_CODE = SEL_W'(NUM_GPR + 1);

  always_comb begin
    data_o = '0;
    if (sel_i == '0)             data_o = acc_i;
    else if (sel_i == FLG_CODE)  data_o = {{(DATA_W-FLAG_W){1'b0}}, flg_i};
    else if (sel_i <= SEL_W'(NUM_GPR)) begin
      for (int i = 0; i < NUM_GPR; i++)
        if (sel_i == SEL_W'(i + 1)) data_o = gpr_i[i];
    end
  end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import drf_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_GPR = 6,
  localparam int unsigned SEL_W  = $clog2(NUM_GPR + 2),
  localparam int unsigned GPR_IW = $clog2(NUM_GPR),
  localparam int unsigned NBANK  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        op_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wb_en_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              bank_o
);
  localparam logic [SEL_W-1:0] FLG_CODE = SEL_W'(NUM_GPR + 1);

  op_kind_e   kind;
  logic [2:0] tgt;

  drf_op_decode u_dec (
    .valid_i(op_valid_i),
    .op_i   (op_i),
    .kind_o (kind),
    .tgt_o  (tgt)
  );

  logic                            bank_q, bank_d;
  logic [NBANK-1:0]                acc_we, flg_we, gpr_we;
  logic [DATA_W-1:0]               acc_d   [NBANK];
  logic [FLAG_W-1:0]               flg_d   [NBANK];
  logic [GPR_IW-1:0]               gpr_idx [NBANK];
  logic [DATA_W-1:0]               gpr_d   [NBANK];
  logic [DATA_W-1:0]               acc_q   [NBANK];
  logic [FLAG_W-1:0]               flg_q   [NBANK];
  logic [NUM_GPR-1:0][DATA_W-1:0]  gpr_q   [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    drf_bank #(
      .DATA_W (DATA_W),
      .NUM_GPR(NUM_GPR),
      .FLAG_W (FLAG_W)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_we_i (acc_we[b]),
      .acc_d_i  (acc_d[b]),
      .flg_we_i (flg_we[b]),
      .flg_d_i  (flg_d[b]),
      .gpr_we_i (gpr_we[b]),
      .gpr_idx_i(gpr_idx[b]),
      .gpr_d_i  (gpr_d[b]),
      .acc_o    (acc_q[b]),
      .flg_o    (flg_q[b]),
      .gpr_o    (gpr_q[b])
    );
  end

  logic [SEL_W-1:0] tgt_s;
  assign tgt_s = SEL_W'(tgt);

  always_comb begin
    bank_d = bank_q;
    acc_we = '0;
    flg_we = '0;
    gpr_we = '0;
    for (int b = 0; b < NBANK; b++) begin
      acc_d[b]   = '0;
      flg_d[b]   = '0;
      gpr_idx[b] = '0;
      gpr_d[b]   = '0;
    end

    unique case (kind)
      OPK_BANK: bank_d = ~bank_q;
      OPK_XACC: begin
        acc_we   = '1;
        acc_d[0] = acc_q[1];
        acc_d[1] = acc_q[0];
      end
      OPK_XFLG: begin
        flg_we   = '1;
        flg_d[0] = flg_q[1];
        flg_d[1] = flg_q[0];
      end
      OPK_XREG: begin
        if (tgt_s == FLG_CODE) begin
          acc_we[bank_q] = 1'b1;
          acc_d[bank_q]  = {{(DATA_W-FLAG_W){1'b0}}, flg_q[bank_q]};
          flg_we[bank_q] = 1'b1;
          flg_d[bank_q]  = acc_q[bank_q][FLAG_W-1:0];
        end else if (tgt_s != '0 && tgt_s <= SEL_W'(NUM_GPR)) begin
          acc_we[bank_q]  = 1'b1;
          acc_d[bank_q]   = gpr_q[bank_q][GPR_IW'(tgt_s - 1'b1)];
          gpr_we[bank_q]  = 1'b1;
          gpr_idx[bank_q] = GPR_IW'(tgt_s - 1'b1);
          gpr_d[bank_q]   = acc_q[bank_q];
        end
      end
      default: ;
    endcase

    // datapath writes only when no operation is strobed
    if (!op_valid_i) begin
      if (wb_en_i) begin
        if (wb_sel_i == '0) begin
          acc_we[bank_q] = 1'b1;
          acc_d[bank_q]  = wb_data_i;
        end else if (wb_sel_i == FLG_CODE) begin
          flg_we[bank_q] = 1'b1;
          flg_d[bank_q]  = wb_data_i[FLAG_W-1:0];
        end else if (wb_sel_i <= SEL_W'(NUM_GPR)) begin
          gpr_we[bank_q]  = 1'b1;
          gpr_idx[bank_q] = GPR_IW'(wb_sel_i - 1'b1);
          gpr_d[bank_q]   = wb_data_i;
        end
      end
      if (flag_we_i) begin
        flg_we[bank_q] = 1'b1;
        flg_d[bank_q]  = flag_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= 1'b0;
    else         bank_q <= bank_d;
  end

  drf_read_mux #(
    .DATA_W (DATA_W),
    .NUM_GPR(NUM_GPR),
    .FLAG_W (FLAG_W),
    .SEL_W  (SEL_W)
  ) u_rd (
    .sel_i (rd_sel_i),
    .acc_i (acc_q[bank_q]),
    .flg_i (flg_q[bank_q]),
    .gpr_i (gpr_q[bank_q]),
    .data_o(rd_data_o)
  );

  assign acc_o   = acc_q[bank_q];
  assign flags_o = {{(DATA_W-FLAG_W){1'b0}}, flg_q[bank_q]};
  assign bank_o  = bank_q;
endmodule

// File: rtl/drf_checker.sv
module drf_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FLAG_W = 2,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [7:0]        op_i,
  input logic [SEL_W-1:0]  rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wb_en_i,
  input logic [SEL_W-1:0]  wb_sel_i,
  input logic [DATA_W-1:0] wb_data_i,
  input logic              flag_we_i,
  input logic [FLAG_W-1:0] flag_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] flags_o,
  input logic              bank_o
);
  logic is_bank, is_xacc, is_xflg, is_xreg_gpr, is_xreg_flg, is_xreg_acc, is_unknown;
  assign is_bank     = op_valid_i && op_i == 8'h99;
  assign is_xacc     = op_valid_i && op_i == 8'h96;
  assign is_xflg     = op_valid_i && op_i == 8'h9A;
  assign is_xreg_flg = op_valid_i && op_i == 8'h57;
  assign is_xreg_acc = op_valid_i && op_i == 8'h50;
  assign is_xreg_gpr = op_valid_i && op_i[7:3] == 5'b01010 && op_i[2:0] != 3'd0 && op_i[2:0] != 3'd7;
  assign is_unknown  = op_valid_i && !is_bank && !is_xacc && !is_xflg && op_i[7:3] != 5'b01010;

  a_r2_bank_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bank |=> bank_o != $past(bank_o));

  a_r2_bank_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_bank |=> $stable(bank_o));

  a_r3_xacc_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xacc |=> $stable(flags_o) && $stable(bank_o));

  a_r4_xflg_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xflg |=> $stable(acc_o) && $stable(bank_o));

  a_r5_xreg_gpr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xreg_gpr && op_i[2:0] == rd_sel_i |=> acc_o == $past(rd_data_o) && $stable(flags_o));

  a_r6_xreg_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xreg_flg |=> acc_o == $past(flags_o) && flags_o[FLAG_W-1:0] == $past(acc_o[FLAG_W-1:0]));

  a_r7_xreg_acc_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xreg_acc |=> $stable(acc_o) && $stable(flags_o) && $stable(bank_o));

  a_r8_flag_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[DATA_W-1:FLAG_W] == '0);

  a_r9_wb_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i && wb_en_i && wb_sel_i == '0 |=> acc_o == $past(wb_data_i));

  a_r10_flag_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i && flag_we_i |=> flags_o[FLAG_W-1:0] == $past(flag_i));

  a_r11_unknown_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_unknown |=> $stable(acc_o) && $stable(flags_o) && $stable(bank_o));
endmodule

bind dual_bank_regfile drf_checker #(
  .DATA_W(DATA_W),
  .FLAG_W(drf_pkg::FLAG_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_valid_i(op_valid_i),
  .op_i      (op_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .wb_en_i   (wb_en_i),
  .wb_sel_i  (wb_sel_i),
  .wb_data_i (wb_data_i),
  .flag_we_i (flag_we_i),
  .flag_i    (flag_i),
  .acc_o     (acc_o),
  .flags_o   (flags_o),
  .bank_o    (bank_o)
);

// File: tb/dual_bank_regfile_tb.sv
`timescale 1ns/100ps
module dual_bank_regfile_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [7:0] op_i = '0;
  logic [2:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic       wb_en_i = 1'b0;
  logic [2:0] wb_sel_i = '0;
  logic [7:0] wb_data_i = '0;
  logic       flag_we_i = 1'b0;
  logic [1:0] flag_i = '0;
  logic [7:0] acc_o, flags_o;
  logic       bank_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dual_bank_regfile u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .wb_en_i(wb_en_i),
    .wb_sel_i(wb_sel_i), .wb_data_i(wb_data_i), .flag_we_i(flag_we_i),
    .flag_i(flag_i), .acc_o(acc_o), .flags_o(flags_o), .bank_o(bank_o)
  );

  // reference state
  logic [7:0] m_acc [2];
  logic [1:0] m_flg [2];
  logic [7:0] m_gpr [2][6];
  logic       m_bank;

  function automatic logic [7:0] m_read(input logic [2:0] s);
    if (s == 3'd0) return m_acc[m_bank];
    if (s == 3'd7) return {6'b0, m_flg[m_bank]};
    return m_gpr[m_bank][s-1];
  endfunction

  task automatic model_step(input logic v, input logic [7:0] op, input logic we,
                            input logic [2:0] ws, input logic [7:0] wd,
                            input logic fwe, input logic [1:0] fv);
    logic [7:0] t;
    logic [1:0] tf;
    if (v) begin
      if (op == 8'h99) m_bank = ~m_bank;
      else if (op == 8'h96) begin t = m_acc[0]; m_acc[0] = m_acc[1]; m_acc[1] = t; end
      else if (op == 8'h9A) begin tf = m_flg[0]; m_flg[0] = m_flg[1]; m_flg[1] = tf; end
      else if (op[7:3] == 5'b01010) begin
        if (op[2:0] == 3'd7) begin
          t = m_acc[m_bank];
          m_acc[m_bank] = {6'b0, m_flg[m_bank]};
          m_flg[m_bank] = t[1:0];
        end else if (op[2:0] != 3'd0) begin
          t = m_acc[m_bank];
          m_acc[m_bank] = m_gpr[m_bank][op[2:0]-1];
          m_gpr[m_bank][op[2:0]-1] = t;
        end
      end
    end else begin
      if (we) begin
        if (ws == 3'd0) m_acc[m_bank] = wd;
        else if (ws == 3'd7) m_flg[m_bank] = wd[1:0];
        else m_gpr[m_bank][ws-1] = wd;
      end
      if (fwe) m_flg[m_bank] = fv;
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] op, input logic we,
                     input logic [2:0] ws, input logic [7:0] wd,
                     input logic fwe, input logic [1:0] fv);
    op_valid_i = v; op_i = op; wb_en_i = we; wb_sel_i = ws; wb_data_i = wd;
    flag_we_i = fwe; flag_i = fv;
    @(posedge clk_i);
    model_step(v, op, we, ws, wd, fwe, fv);
    @(negedge clk_i);
    op_valid_i = 0; op_i = '0; wb_en_i = 0; wb_sel_i = '0; wb_data_i = '0;
    flag_we_i = 0; flag_i = '0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // sweeps all selectors of the active bank; inputs are idle meanwhile
  task automatic check_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      rd_sel_i = 3'(s);
      #0.2;
      chk({tag, " R8 rd"}, rd_data_o, m_read(3'(s)));
    end
    chk({tag, " acc"}, acc_o, m_acc[m_bank]);
    chk({tag, " R8 flags"}, flags_o, {6'b0, m_flg[m_bank]});
    chk({tag, " bank"}, {7'b0, bank_o}, {7'b0, m_bank});
  endtask

  task automatic check_both(input string tag);
    check_all(tag);
    cyc(1, 8'h99, 0, 0, 0, 0, 0);
    check_all({tag, " passive"});
    cyc(1, 8'h99, 0, 0, 0, 0, 0);
  endtask

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    m_bank = 0;
    for (int b = 0; b < 2; b++) begin
      m_acc[b] = '0; m_flg[b] = '0;
      for (int i = 0; i < 6; i++) m_gpr[b][i] = '0;
    end
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    check_both("R1 reset");

    // R9 fill bank 0, code 7 keeps two bits
    for (int s = 0; s < 8; s++) cyc(0, 0, 1, 3'(s), 8'(8'h10 + 8'h11 * s) | 8'hFC * (s == 7), 0, 0);
    check_all("R9 fill bank0");

    // R2 toggle and fill bank 1
    cyc(1, 8'h99, 0, 0, 0, 0, 0);
    check_all("R2 toggled");
    for (int s = 0; s < 8; s++) cyc(0, 0, 1, 3'(s), 8'(8'hA0 + 8'h07 * s), 0, 0);
    check_both("R9 fill bank1");
    cyc(1, 8'h99, 0, 0, 0, 0, 0);
    check_all("R2 bank0 retained");

    cyc(1, 8'h96, 0, 0, 0, 0, 0);
    check_both("R3 acc swap");
    cyc(1, 8'h9A, 0, 0, 0, 0, 0);
    check_both("R4 flag swap");

    for (int r = 0; r < 8; r++) begin
      cyc(1, 8'(8'h50 + r), 0, 0, 0, 0, 0);
      if (r == 0) check_both("R7 acc target");
      else if (r == 7) check_both("R6 flag target");
      else check_both("R5 gpr exchange");
    end

    cyc(0, 0, 0, 0, 0, 1, 2'b10);
    check_all("R10 flag update");
    cyc(0, 0, 1, 3'd7, 8'h01, 1, 2'b10);
    check_all("R10 precedence");
    cyc(0, 0, 1, 3'd7, 8'h03, 0, 0);
    check_all("R9 flags via wb");

    cyc(1, 8'h99, 1, 3'd0, 8'h5A, 1, 2'b11);
    check_both("R11 wb during toggle");
    cyc(1, 8'h00, 1, 3'd2, 8'h77, 1, 2'b01);
    check_both("R11 unknown op");
    cyc(1, 8'h58, 1, 3'd1, 8'h33, 0, 0);
    check_both("R11 unknown 0x58");

    for (int n = 0; n < 1500; n++) begin
      logic [7:0] op;
      rng = nxt(rng);
      case (rng[2:0])
        3'd0: op = 8'h99;
        3'd1: op = 8'h96;
        3'd2: op = 8'h9A;
        3'd3, 3'd4: op = {5'b01010, rng[5:3]};
        default: op = rng[13:6];
      endcase
      if (rng[16:15] == 2'b00)
        cyc(1, op, rng[17], rng[20:18], rng[28:21], rng[29], rng[31:30]);
      else
        cyc(0, 0, rng[17], rng[20:18], rng[28:21], rng[29], rng[31:30]);
      check_all("R5 R9 R10 mixed");
    end
    check_both("R2 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule